// File: doc/BRIEF.md
# Edge-Interval Window Checker

This block decides whether a demodulated, already synchronized bit stream looks like a real transmission or like noise. It times the gap between successive level changes of the stream in units of an extended-clock tick and compares every gap against a programmable window given by a lower and an upper limit. A run of gaps that all fall inside the window ends in a one-cycle success pulse. The first gap that is too short or too long ends the run at once in a one-cycle failure pulse.

A controller pulses the start input with a required bit count and the two limits applied. Each bit of a two-edge line code such as Manchester or bi-phase yields two gaps, so success needs twice the bit count of consecutive good gaps. The first level change after start only opens the first gap. An edge that is too early fails when it arrives. A missing edge fails as soon as the gap counter reaches the upper limit, without waiting for any edge. After either pulse the block goes idle until the next start. Typical limits are 14 and 24. Usable values are a lower limit of at least 10 and an upper limit from 12 to 63.

Top module: `edge_window_checker`

## Requirements
- R1: Out of reset both result outputs are low and the block is idle, so data edges produce no pulse until a start strobe is seen.
- R2: The first data edge after the start strobe only starts the first gap and is never judged, however long the block waited for it.
- R3: The gap value judged at an edge is the number of cycles with tick_i high after the previous edge's cycle and before this edge's cycle. An edge and a tick in the same cycle count as an edge.
- R4: A gap value v with lim_lo_i ≤ v < lim_hi_i passes, and the next gap starts from zero in the edge's cycle.
- R5: An edge whose gap value is below lim_lo_i drives done_err_o high in the cycle after that edge.
- R6: When ticks without an edge bring the gap count to lim_hi_i, done_err_o goes high in the next cycle without waiting for an edge.
- R7: With bits_i = N > 0, done_ok_o goes high in the cycle after the 2·N-th consecutive passing gap.
- R8: A start strobe with bits_i = 0 drives done_ok_o high in the next cycle.
- R9: done_ok_o and done_err_o are one-cycle pulses, never high together, and after either one the block is idle and ignores edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a check run when idle |
| data_i | input | 1 | Synchronized demodulated data level |
| tick_i | input | 1 | Extended-clock tick, advances the gap counter |
| bits_i | input | BITS_W (4) | Required bit count, sampled throughout a run |
| lim_lo_i | input | LIM_W (6) | Lower window limit in ticks |
| lim_hi_i | input | LIM_W (6) | Upper window limit in ticks |
| done_ok_o | output | 1 | Success pulse |
| done_err_o | output | 1 | Failure pulse |

## Verification
The bench goes after gap values exactly on lim_lo_i and one below the upper limit, which pass, and after values one below the lower limit and exactly on the upper limit, which fail. An off-by-one comparison would flip one of these outcomes or move the pulse by one cycle. It checks that the timeout fires at the upper limit with no edge present, since a design that waited for the edge would report late or never. It also checks that a wait before the first edge is not judged, that a bad gap after good ones fails at that edge, and that a tick gated to every other cycle halves the gap count. A design that counted cycles instead of ticks would time out in that case. Zero required bits and idle edges after a result are covered as well.

// File: rtl/ewc_pkg.sv
// Shared types of the edge-interval window checker.
package ewc_pkg;

    // Controller phase: idle, waiting for the first edge, timing gaps.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_TIME = 2'd2
    } ewc_state_t;

endpackage

// File: rtl/ewc_edge_detect.sv
// Flags a change of the synchronized data level against its value one cycle
// earlier. Assumes level_i is already synchronous to clk.
module ewc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);
    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/ewc_interval_counter.sv
// Gap counter: clears on request, otherwise advances by one when enabled.
// Assumes the caller keeps the value below 2**W by ending the gap in time.
module ewc_interval_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         adv_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    // Clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (adv_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/ewc_window_judge.sv
// Combinational verdict on the current gap. early_o: edge below the lower
// limit. ok_o: edge at or above the lower limit (the upper bound is ensured
// because the gap would already have timed out). late_o: a tick without an
// edge would bring the count to the upper limit.
module ewc_window_judge #(
    parameter int W = 6
) (
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] lim_lo_i,
    input  logic [W-1:0] lim_hi_i,
    input  logic         edge_i,
    input  logic         tick_i,
    output logic         early_o,
    output logic         ok_o,
    output logic         late_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] cnt_plus;

    // Widen before increment so a count of 2**W-1 does not wrap.
    always_comb begin
        cnt_plus = {1'b0, count_i} + WX'(1);
        early_o  = edge_i && (count_i < lim_lo_i);
        ok_o     = edge_i && (count_i >= lim_lo_i);
        late_o   = !edge_i && tick_i && (cnt_plus >= {1'b0, lim_hi_i});
    end
endmodule

// File: rtl/ewc_pass_counter.sv
// Counts passing gaps of the current run and flags when the next pass
// completes the required number of gaps (twice the bit count).
module ewc_pass_counter #(
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              inc_i,
    input  logic [BITS_W-1:0] bits_i,
    output logic              last_o
);
    localparam int CW = BITS_W + 1;

    logic [CW-1:0] pass_q;
    logic [CW-1:0] need;

    // Clear between runs, step on each passing gap.
    always_ff @(posedge clk) begin
        if (!rst_n)       pass_q <= '0;
        else if (clear_i) pass_q <= '0;
        else if (inc_i)   pass_q <= pass_q + 1'b1;
    end

    // Two gaps per bit; the run ends on the pass that reaches this count.
    always_comb begin
        need   = {bits_i, 1'b0};
        last_o = (pass_q + CW'(1)) == need;
    end
endmodule

// File: rtl/edge_window_checker.sv
// Top of the edge-interval window checker. A start strobe arms the block.
// The first edge opens timing, each later edge is judged against the window,
// and the run ends in a one-cycle ok or error pulse. Assumes data_i and tick_i
// are synchronous to clk and the limits are stable during a run.
module edge_window_checker #(
    parameter int LIM_W  = 6,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              data_i,
    input  logic              tick_i,
    input  logic [BITS_W-1:0] bits_i,
    input  logic [LIM_W-1:0]  lim_lo_i,
    input  logic [LIM_W-1:0]  lim_hi_i,
    output logic              done_ok_o,
    output logic              done_err_o
);
    import ewc_pkg::*;

    ewc_state_t       state_q;
    logic             edge_w;
    logic [LIM_W-1:0] ivl_cnt;
    logic             early_w, ok_w, late_w, last_w;
    logic             ok_q, err_q;
    logic             timing, ivl_clear, ivl_adv;

    ewc_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (data_i),
        .edge_o  (edge_w)
    );

    // Gap counter controls: restart on any edge while armed or timing.
    always_comb begin
        timing    = (state_q == ST_TIME);
        ivl_clear = edge_w && (state_q != ST_IDLE);
        ivl_adv   = timing && tick_i && !edge_w;
    end

    ewc_interval_counter #(.W(LIM_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ivl_clear),
        .adv_i   (ivl_adv),
        .count_o (ivl_cnt)
    );

    ewc_window_judge #(.W(LIM_W)) u_judge (
        .count_i  (ivl_cnt),
        .lim_lo_i (lim_lo_i),
        .lim_hi_i (lim_hi_i),
        .edge_i   (edge_w),
        .tick_i   (tick_i),
        .early_o  (early_w),
        .ok_o     (ok_w),
        .late_o   (late_w)
    );

    ewc_pass_counter #(.BITS_W(BITS_W)) u_pass (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_IDLE),
        .inc_i   (timing && ok_w),
        .bits_i  (bits_i),
        .last_o  (last_w)
    );

    // Run controller and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ok_q  <= 1'b0;
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (bits_i == '0) ok_q    <= 1'b1;
                        else              state_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (edge_w) state_q <= ST_TIME;
                end
                ST_TIME: begin
                    if (early_w || late_w) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (ok_w && last_w) begin
                        ok_q    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_ok_o  = ok_q;
    assign done_err_o = err_q;
endmodule

// File: rtl/ewc_checker.sv
// Assertion checker for the edge-interval window checker, bound to the top.
module ewc_checker #(
    parameter int LIM_W  = 6,
    parameter int BITS_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [BITS_W-1:0]  bits_i,
    input logic [LIM_W-1:0]   lim_lo_i,
    input logic [LIM_W-1:0]   lim_hi_i,
    input logic               tick_i,
    input logic               done_ok_o,
    input logic               done_err_o,
    input ewc_pkg::ewc_state_t state,
    input logic               edge_seen,
    input logic [LIM_W-1:0]   ivl
);
    import ewc_pkg::*;

    // R9
    exclusive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && done_err_o));

    // R9
    ok_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |=> !done_ok_o);

    // R9
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_err_o |=> !done_err_o);

    // R9
    idle_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok_o || done_err_o) |-> state == ST_IDLE);

    // R8
    zero_bits_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && bits_i == '0) |=> done_ok_o);

    // R5
    early_edge_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIME && edge_seen && ivl < lim_lo_i) |=> done_err_o);

    // R6
    timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIME && !edge_seen && tick_i &&
         ({1'b0, ivl} + 1'b1) == {1'b0, lim_hi_i}) |=> done_err_o);

    // R2
    first_edge_unjudged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> !done_err_o && !done_ok_o);

    // R3
    gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && edge_seen) |=> ivl == '0);
endmodule

bind edge_window_checker ewc_checker #(.LIM_W(LIM_W), .BITS_W(BITS_W)) u_ewc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bits_i     (bits_i),
    .lim_lo_i   (lim_lo_i),
    .lim_hi_i   (lim_hi_i),
    .tick_i     (tick_i),
    .done_ok_o  (done_ok_o),
    .done_err_o (done_err_o),
    .state      (state_q),
    .edge_seen  (edge_w),
    .ivl        (ivl_cnt)
);

// File: tb/edge_window_checker_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module edge_window_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       data_i = 1'b0;
    logic       tick_i = 1'b1;
    logic [3:0] bits_i = 4'd0;
    logic [5:0] lim_lo_i = 6'd14;
    logic [5:0] lim_hi_i = 6'd24;
    logic       done_ok_o, done_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    edge_window_checker u_edge_window_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .data_i     (data_i),
        .tick_i     (tick_i),
        .bits_i     (bits_i),
        .lim_lo_i   (lim_lo_i),
        .lim_hi_i   (lim_hi_i),
        .done_ok_o  (done_ok_o),
        .done_err_o (done_err_o)
    );

    // bits, lo, hi, tick divider, wait before first edge, gap, alternate gap,
    // toggle number after which the alternate gap is used (0: never),
    // expected ok (1) or error (0), expected cycle index of the pulse counted
    // from the first edge's cycle, and the requirement under test.
    typedef struct packed {
        logic [3:0]  bits;
        logic [5:0]  lo;
        logic [5:0]  hi;
        logic [1:0]  div;
        logic [7:0]  pre;
        logic [6:0]  gap;
        logic [6:0]  gap_alt;
        logic [3:0]  alt_at;
        logic        exp_ok;
        logic [7:0]  exp_idx;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [0:NV-1] = '{
        '{4'd1, 6'd14, 6'd24, 2'd1, 8'd50, 7'd20, 7'd20, 4'd0, 1'b1, 8'd40,  "R2"},
        '{4'd3, 6'd14, 6'd24, 2'd1, 8'd0,  7'd15, 7'd15, 4'd0, 1'b1, 8'd90,  "R4"},
        '{4'd2, 6'd14, 6'd24, 2'd1, 8'd0,  7'd14, 7'd14, 4'd0, 1'b0, 8'd14,  "R5"},
        '{4'd2, 6'd14, 6'd24, 2'd1, 8'd0,  7'd24, 7'd24, 4'd0, 1'b1, 8'd96,  "R4"},
        '{4'd2, 6'd14, 6'd24, 2'd1, 8'd0,  7'd25, 7'd25, 4'd0, 1'b0, 8'd24,  "R6"},
        '{4'd9, 6'd10, 6'd12, 2'd1, 8'd0,  7'd11, 7'd11, 4'd0, 1'b1, 8'd198, "R7"},
        '{4'd1, 6'd10, 6'd12, 2'd1, 8'd0,  7'd13, 7'd13, 4'd0, 1'b0, 8'd12,  "R6"},
        '{4'd1, 6'd3,  6'd6,  2'd2, 8'd0,  7'd8,  7'd8,  4'd0, 1'b1, 8'd16,  "R3"},
        '{4'd1, 6'd30, 6'd63, 2'd1, 8'd0,  7'd63, 7'd63, 4'd0, 1'b1, 8'd126, "R4"},
        '{4'd2, 6'd14, 6'd24, 2'd1, 8'd0,  7'd20, 7'd10, 4'd3, 1'b0, 8'd50,  "R7"}
    };

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int  hit_idx = -1;
        bit  hit_ok  = 1'b0;
        bit  quiet   = 1'b1;
        int  next_t  = 0;
        int  n_tog   = 0;
        string rq;
        rq = string'(v.req);
        @(negedge clk);
        bits_i = v.bits; lim_lo_i = v.lo; lim_hi_i = v.hi;
        tick_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int p = 0; p < int'(v.pre); p++) begin
            @(negedge clk);
            if (done_ok_o || done_err_o) quiet = 1'b0;
        end
        check(quiet, "R2", int'(quiet), 1);
        for (int k = 0; k < 260 && hit_idx < 0; k++) begin
            @(negedge clk);
            tick_i = (v.div == 2'd1) ? 1'b1 : ((k % int'(v.div)) == int'(v.div) - 1);
            if (k == next_t) begin
                data_i = ~data_i;
                n_tog++;
                next_t += (n_tog == int'(v.alt_at)) ? int'(v.gap_alt) : int'(v.gap);
            end
            @(posedge clk);
            #1;
            if (done_ok_o || done_err_o) begin
                hit_idx = k;
                hit_ok  = done_ok_o;
            end
        end
        check(hit_ok == v.exp_ok && hit_idx == int'(v.exp_idx), rq,
              hit_idx * 2 + int'(hit_ok), int'(v.exp_idx) * 2 + int'(v.exp_ok));
        // R9: pulse lasts one cycle
        @(posedge clk);
        #1;
        check(!done_ok_o && !done_err_o, "R9", int'({done_ok_o, done_err_o}), 0);
        // R9: idle ignores edges after a result
        quiet = 1'b1;
        tick_i = 1'b1;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (j % 3 == 0) data_i = ~data_i;
            if (done_ok_o || done_err_o) quiet = 1'b0;
        end
        check(quiet, "R9", int'(quiet), 1);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit quiet;
        repeat (3) @(negedge clk);
        // R1: outputs low in reset and after release, edges ignored
        check(!done_ok_o && !done_err_o, "R1", int'({done_ok_o, done_err_o}), 0);
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            if (j % 5 == 0) data_i = ~data_i;
            if (done_ok_o || done_err_o) quiet = 1'b0;
        end
        check(quiet, "R1", int'(quiet), 1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: zero bits gives ok in the cycle after start
        @(negedge clk);
        bits_i = 4'd0; start_i = 1'b1;
        @(posedge clk);
        #1;
        check(done_ok_o && !done_err_o, "R8", int'({done_ok_o, done_err_o}), 2);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk);
        #1;
        check(!done_ok_o, "R9", int'(done_ok_o), 0);

        // R1: reset in the middle of a run returns to idle
        @(negedge clk);
        bits_i = 4'd2; lim_lo_i = 6'd14; lim_hi_i = 6'd24; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        data_i = ~data_i;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            if (done_ok_o || done_err_o) quiet = 1'b0;
        end
        check(quiet, "R1", int'(quiet), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule